// File: doc/BRIEF.md
# Configurable Serial Line Transmitter

This block turns bytes into asynchronous serial frames on one output line. A byte offered with a single-cycle load strobe lands in a one-entry holding register. As soon as the shift engine is free, the byte moves into the engine and the holding register can accept the next byte. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period. The line rests high between frames.

A 7-bit control word sets the frame shape. It is read live, so the surrounding logic keeps it steady while a frame is in flight; the break bit is the one field meant to change at any time. Bit timing comes from an external enable pulse at sixteen times the bit rate, so one bit lasts sixteen pulses. Two flags report progress: one says the holding register is free, the other says nothing is left to send.

Top module: `sertx`

## Requirements
- R1: After reset the line is high and both the holding-empty and the transmitter-empty flags are high. While no frame is in progress and break is clear, the line is high.
- R2: A frame begins with a start bit held low for 16 tick pulses. It continues with the data bits, least significant first, each held for 16 tick pulses. Control bits [1:0] set the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8. The line never changes between tick pulses while the control word is steady.
- R3: The stop period is high. With control bit 2 clear it lasts 16 ticks. With control bit 2 set it lasts 24 ticks for a 5-bit length and 32 ticks for 6, 7 or 8 bits.
- R4: With control bit 3 set, one parity bit of 16 ticks follows the data bits. Control bit 4 = 0 picks even parity (data ones plus the parity bit form an even count), and 1 picks odd parity.
- R5: With control bits 3 and 5 both set, the parity bit is fixed at the value of control bit 4, whatever the data.
- R6: While control bit 6 is set the line is low, both in frames and when idle. Frame timing and the flag timing are the same as with break clear.
- R7: A load strobe while the holding register is empty clears the holding-empty flag at the next clock edge. If the shift engine is idle, the byte moves into it one clock later and holding-empty is set again.
- R8: A load strobe while the holding register is full is ignored: the held byte is kept and no extra frame is sent.
- R9: The transmitter-empty flag is high only when the holding register is empty and no frame is in progress. It rises at the clock edge that ends the last stop tick.
- R10: A byte waiting in the holding register starts its start bit on the tick right after the previous frame's last stop tick, with no idle tick in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 7 | Frame control: [1:0] length, [2] long stop, [3] parity on, [4] odd, [5] stick, [6] break |
| load_i | input | 1 | Single-cycle strobe that offers load_byte |
| load_byte | input | 8 | Byte to send |
| tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| txd_o | output | 1 | Serial line, idle high |
| hold_empty_o | output | 1 | Holding register is free |
| tx_empty_o | output | 1 | Holding register empty and no frame in progress |

## Verification
A wrong tick count or bit index shows up directly at the line. A bit that lasts the wrong number of ticks, or a parity or stop period of the wrong length, moves every later sample. It also moves the edge where the transmitter-empty flag rises, so the error appears within the frame it happens in. A fault in the holding register shows up as a missing, repeated or corrupted second frame in back-to-back traffic. Holding-empty errors show up one or two cycles after a load strobe. Tick pulses are spaced at random, which shows whether the state advances on anything other than a tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    parameter int TICKS_PER_BIT = 16;
    parameter int DATA_W        = 8;
    parameter int CTRL_W        = 7;
    localparam int CNT_W  = $clog2(2 * TICKS_PER_BIT + 1);
    localparam int NBIT_W = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [NBIT_W-1:0] nbits;
        logic [CNT_W-1:0]  stop_ticks;
        logic              par_en;
        logic              par_odd;
        logic              par_stick;
        logic              brk;
    } fmt_t;

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [NBIT_W-1:0] bitn;
        logic [DATA_W-1:0] sh;
        logic              par;
    } shift_regs_t;

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_regs_t;
endpackage

// File: rtl/sertx_fmt.sv
module sertx_fmt
    import sertx_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output fmt_t              fmt
);
    localparam logic [CNT_W-1:0] ONE_STOP   = CNT_W'(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] HALF_STOP  = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    localparam logic [CNT_W-1:0] TWO_STOP   = CNT_W'(2 * TICKS_PER_BIT);
    localparam logic [NBIT_W-1:0] MIN_BITS  = NBIT_W'(DATA_W - 3);

    always_comb begin
        fmt.nbits     = MIN_BITS + NBIT_W'(ctrl[1:0]);
        fmt.par_en    = ctrl[3];
        fmt.par_odd   = ctrl[4];
        fmt.par_stick = ctrl[5];
        fmt.brk       = ctrl[6];
        if (!ctrl[2])
            fmt.stop_ticks = ONE_STOP;
        else if (ctrl[1:0] == 2'b00)
            fmt.stop_ticks = HALF_STOP;
        else
            fmt.stop_ticks = TWO_STOP;
    end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    hold_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.full && load) begin
            r_d.full = 1'b1;
            r_d.data = load_byte;
        end else if (r_q.full && take) begin
            r_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign full = r_q.full;
    assign data = r_q.data;
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              line
);
    localparam logic [CNT_W-1:0] BIT_TICKS = CNT_W'(TICKS_PER_BIT);

    shift_regs_t       s_d, s_q;
    logic [CNT_W-1:0]  limit;
    logic [DATA_W-1:0] mask;
    logic              par_calc;
    logic              do_load;

    always_comb begin
        mask     = {DATA_W{1'b1}} >> (NBIT_W'(DATA_W) - fmt.nbits);
        par_calc = fmt.par_stick ? fmt.par_odd : ((^(hold_data & mask)) ^ fmt.par_odd);
        limit    = (s_q.st == ST_STOP) ? fmt.stop_ticks : BIT_TICKS;
        s_d      = s_q;
        do_load  = 1'b0;

        if (s_q.st == ST_IDLE) begin
            do_load = hold_full;
        end else if (tick) begin
            if (s_q.cnt == limit - 1'b1) begin
                s_d.cnt = '0;
                case (s_q.st)
                    ST_START: begin
                        s_d.st   = ST_DATA;
                        s_d.bitn = '0;
                    end
                    ST_DATA: begin
                        s_d.sh   = s_q.sh >> 1;
                        s_d.bitn = s_q.bitn + 1'b1;
                        if (s_q.bitn == fmt.nbits - 1'b1)
                            s_d.st = fmt.par_en ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  s_d.st = ST_STOP;
                    default: begin
                        s_d.st  = ST_IDLE;
                        do_load = hold_full;
                    end
                endcase
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (do_load) begin
            s_d.st   = ST_START;
            s_d.cnt  = '0;
            s_d.bitn = '0;
            s_d.sh   = hold_data;
            s_d.par  = par_calc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{st: ST_IDLE, default: '0};
        else
            s_q <= s_d;
    end

    always_comb begin
        case (s_q.st)
            ST_START: line = 1'b0;
            ST_DATA:  line = s_q.sh[0];
            ST_PAR:   line = s_q.par;
            default:  line = 1'b1;
        endcase
        if (fmt.brk)
            line = 1'b0;
    end

    assign take = do_load;
    assign busy = (s_q.st != ST_IDLE);
endmodule

// File: rtl/sertx.sv
module sertx
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              tick_i,
    output logic              txd_o,
    output logic              hold_empty_o,
    output logic              tx_empty_o
);
    fmt_t              fmt;
    logic              hold_full;
    logic [DATA_W-1:0] hold_byte;
    logic              take;
    logic              busy;

    sertx_fmt u_fmt (
        .ctrl (ctrl_word),
        .fmt  (fmt)
    );

    sertx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_i),
        .load_byte (load_byte),
        .take      (take),
        .full      (hold_full),
        .data      (hold_byte)
    );

    sertx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .fmt       (fmt),
        .hold_full (hold_full),
        .hold_data (hold_byte),
        .take      (take),
        .busy      (busy),
        .line      (txd_o)
    );

    assign hold_empty_o = !hold_full;
    assign tx_empty_o   = !hold_full && !busy;
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker
    import sertx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              load_i,
    input logic              tick_i,
    input logic              txd_o,
    input logic              hold_empty_o,
    input logic              tx_empty_o,
    input logic              busy,
    input logic [DATA_W-1:0] hold_byte
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl_word[6]) |-> txd_o);

    assert_no_tick_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_i) |=> ($stable(txd_o) || !$stable(ctrl_word)));

    assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[6] |-> !txd_o);

    assert_load_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && hold_empty_o) |=> !hold_empty_o);

    assert_full_keeps_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_empty_o |=> $stable(hold_byte));

    assert_empty_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_o |-> (hold_empty_o && !busy));
endmodule

bind sertx sertx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_word    (ctrl_word),
    .load_i       (load_i),
    .tick_i       (tick_i),
    .txd_o        (txd_o),
    .hold_empty_o (hold_empty_o),
    .tx_empty_o   (tx_empty_o),
    .busy         (busy),
    .hold_byte    (hold_byte)
);

// File: tb/sertx_test.sv
module sertx_test;
    typedef bit bitq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ctrl_word = '0;
    logic       load_i = 1'b0;
    logic [7:0] load_byte = '0;
    logic       tick_i = 1'b0;
    logic       txd_o, hold_empty_o, tx_empty_o;

    int    checks = 0;
    int    errors = 0;
    bitq_t got;

    always #2.5 clk = ~clk;

    sertx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_word    (ctrl_word),
        .load_i       (load_i),
        .load_byte    (load_byte),
        .tick_i       (tick_i),
        .txd_o        (txd_o),
        .hold_empty_o (hold_empty_o),
        .tx_empty_o   (tx_empty_o)
    );

    function automatic bitq_t frame_bits(logic [7:0] b, logic [6:0] c);
        bitq_t q;
        int n = 5 + int'(c[1:0]);
        int stop;
        bit p;
        logic [7:0] m;
        repeat (16) q.push_back(1'b0);
        for (int i = 0; i < n; i++) repeat (16) q.push_back(b[i]);
        if (c[3]) begin
            m = b & (8'hFF >> (8 - n));
            p = c[5] ? c[4] : ((^m) ^ c[4]);
            repeat (16) q.push_back(p);
        end
        stop = !c[2] ? 16 : ((n == 5) ? 24 : 32);
        repeat (stop) q.push_back(1'b1);
        if (c[6]) foreach (q[i]) q[i] = 1'b0;
        return q;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic collect();
        got = {};
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (tx_empty_o) begin
                tick_i = 1'b0;
                return;
            end
            tick_i = 1'($urandom % 2);
            if (tick_i) got.push_back(txd_o);
        end
        tick_i = 1'b0;
        check(1'b0, "R9", "transmitter never emptied", 0, 1);
    endtask

    task automatic compare(bitq_t exp, string tag);
        int bad = -1;
        check(got.size() == exp.size(), tag, "frame length in ticks", got.size(), exp.size());
        foreach (exp[i]) if (bad < 0 && (i >= got.size() || got[i] != exp[i])) bad = i;
        if (bad >= 0 && bad < got.size())
            check(1'b0, tag, $sformatf("line at tick %0d", bad), int'(got[bad]), int'(exp[bad]));
        else
            check(bad < 0, tag, "line samples", bad, -1);
    endtask

    task automatic send(logic [7:0] b, logic [6:0] c, string tag);
        ctrl_word = c;
        @(negedge clk);
        load_i = 1'b1;
        load_byte = b;
        @(negedge clk);
        load_i = 1'b0;
        check(hold_empty_o == 1'b0, "R7", "hold empty after load", int'(hold_empty_o), 0);
        collect();
        compare(frame_bits(b, c), tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bitq_t exp2;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(txd_o == 1'b1, "R1", "line in reset", int'(txd_o), 1);
        check(hold_empty_o == 1'b1, "R1", "hold empty in reset", int'(hold_empty_o), 1);
        check(tx_empty_o == 1'b1, "R1", "tx empty in reset", int'(tx_empty_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd_o == 1'b1, "R1", "idle line", int'(txd_o), 1);

        // R3: stop lengths
        send(8'h15, 7'b000_0_1_00, "R3");
        send(8'hA6, 7'b000_0_1_01, "R3");
        send(8'h3C, 7'b000_0_0_11, "R3");
        // R4: even and odd parity
        send(8'hB7, 7'b00_0_1_0_11, "R4");
        send(8'h5A, 7'b00_1_1_0_10, "R4");
        send(8'h01, 7'b00_1_1_1_00, "R4");
        // R5: stick parity, both values
        send(8'hFF, 7'b01_1_1_0_11, "R5");
        send(8'hFE, 7'b01_0_1_0_11, "R5");
        // R6: break during a frame keeps timing
        send(8'h55, 7'b100_1_1_11, "R6");
        ctrl_word = 7'h40;
        repeat (3) @(negedge clk);
        check(txd_o == 1'b0, "R6", "idle line under break", int'(txd_o), 0);
        ctrl_word = 7'h00;
        @(negedge clk);
        check(txd_o == 1'b1, "R1", "idle line after break", int'(txd_o), 1);

        // R7 R8 R10: back-to-back, third load ignored
        ctrl_word = 7'b000_1_0_11;
        @(negedge clk);
        load_i = 1'b1;
        load_byte = 8'hC3;
        @(negedge clk);
        load_i = 1'b0;
        check(hold_empty_o == 1'b0, "R7", "hold full after first load", int'(hold_empty_o), 0);
        @(negedge clk);
        check(hold_empty_o == 1'b1, "R7", "hold freed by transfer", int'(hold_empty_o), 1);
        check(tx_empty_o == 1'b0, "R9", "tx busy with frame", int'(tx_empty_o), 0);
        load_i = 1'b1;
        load_byte = 8'h69;
        @(negedge clk);
        check(hold_empty_o == 1'b0, "R8", "hold full before extra load", int'(hold_empty_o), 0);
        load_byte = 8'h0F;
        @(negedge clk);
        load_i = 1'b0;
        collect();
        exp2 = {frame_bits(8'hC3, ctrl_word), frame_bits(8'h69, ctrl_word)};
        compare(exp2, "R10");
        check(hold_empty_o == 1'b1, "R8", "no third frame pending", int'(hold_empty_o), 1);

        // R2: random formats and data
        for (int i = 0; i < 16; i++) begin
            logic [6:0] c = 7'($urandom) & 7'h3F;
            logic [7:0] b = 8'($urandom);
            send(b, c, "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule